// File: doc/BRIEF.md
# Auto-Indexing Controller Register Port

This block is the byte-wide register front end of a disc data controller. A host reaches a whole file of control and status bytes through one data port. The index selects the register. It can be loaded through a separate select port, and it then moves on by one after every read or write. The same index names different registers for reads and for writes. Some accesses have side effects: they start or acknowledge a transfer, clear a pending decoder flag, or reset the whole file.

The block holds the interface control and status bytes, the 16-bit byte counter, the data address, write address and block pointer, two control bytes, the status bytes and a captured four-byte sector header. It presents the counter and the data address to an external transfer engine, together with one-cycle start and abort strobes. It takes two inputs back: a transfer-end pulse from the engine, and a header-capture pulse from the sector decoder. From these it keeps one interrupt line.

Top module: `ctl_regport`

## Requirements
- R1: The index loads from `idx_in` when `idx_we` is high. Otherwise every access at a nonzero index moves it up by one, so an access at index 15 moves it to 0. An access at index 0 changes nothing, and the index stays at 0.
- R2: Read map. `rd_data` shows the register at the current index as follows:
  - 0: 0xFF
  - 1: interface status
  - 2 and 3: counter low and high byte
  - 4 to 7: header bytes 0 to 3
  - 8 and 9: block pointer low and high byte
  - 10 and 11: write address low and high byte
  - 12: status 0
  - 13: 0x00
  - 14: status 2
  - 15: status 3

  A write at index 14 or index 0 has no effect.
- R3: When `dec_hit` is high and control 0 bit 7 is set, header byte k is loaded from `dec_hdr[8k+7:8k]`. Status 3 becomes 0x00 and interface status bit 5 is cleared. If interface control bit 5 is set, `irq` is raised. When control 1 bit 0 is 1, reads at indices 4 to 7 return 0x00.
- R4: After reset the registers hold these values:
  - interface status: 0xFF
  - status 3: 0x80
  - header bytes 0 to 3: 00, 00, 00, 01
  - all other registers: 0
  - index: 0
  - `irq`: 0

  Writes at the following indices load these registers:
  - 2 and 3: counter
  - 4 and 5: data address
  - 8 and 9: write address
  - 12 and 13: block pointer
- R5: A write at index 6 acts only when interface control bit 1 is set. It clears interface status bits 3 and 1 and counter bits 15:12, and it pulses `xfer_start` for one cycle.
- R6: A write at index 7 sets interface status bit 6 and clears counter bits 15:12.
- R7: A write at index 10 loads control 0. Status 0 becomes the written byte AND 0x80.
- R8: Status 2 bit 3 equals control 1 bit 3. Status 2 bit 2 equals control 1 bit 2 when control 0 bit 4 is clear, and is 0 otherwise. All other bits of status 2 are 0.
- R9: A write at index 1 loads interface control and sets `irq` to ((data bit 6 AND NOT status bit 6) OR (data bit 5 AND NOT status bit 5)). `irq` falls only on such a write, on a soft reset, or on reset.
- R10: A write at index 1 with data bit 1 clear sets interface status bits 3 and 1 and pulses `xfer_abort` for one cycle.
- R11: A pulse on `xfer_end` does three things:
  - loads the counter with 0xF000
  - sets interface status bits 3 and 1, and clears bit 6
  - raises `irq` if interface control bit 6 is set
- R12: A read at index 15 sets status 3 to 0x80 and sets interface status bit 5.
- R13: A write at index 15 restores every register to its reset value and sets the index to 0, even when `idx_we` is high in the same cycle.
- R14: When a register write and an engine or decoder pulse fall in the same cycle, the pulse is applied first and the write is applied on top of its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the index from `idx_in` |
| idx_in | input | 4 | New index value |
| rd_en | input | 1 | Read strobe; side effects and index step |
| wr_en | input | 1 | Write strobe; has precedence over `rd_en` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register at the current index (read map) |
| xfer_end | input | 1 | Transfer finished pulse from the engine |
| dec_hit | input | 1 | Sector header captured pulse |
| dec_hdr | input | 32 | Captured header, byte k in bits 8k+7:8k |
| cnt_val | output | 16 | Byte counter value for the engine |
| dac_val | output | 16 | Data address for the engine |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_abort | output | 1 | One-cycle transfer abort strobe |
| irq | output | 1 | Interrupt request |

## Verification
A host write and an engine pulse can land in the same clock cycle. The bench does this on purpose: it raises `xfer_end` in the very cycle that writes the acknowledge at index 7. It then expects the acknowledge to win on the end flag, the counter high nibble to be cleared after the 0xF000 load, and the end pulse to still raise `irq`. The bench also lands a soft-reset write in the same cycle as an index load, and expects the index to be 0 afterwards. Status 2 is swept over every combination of the auto bit and the low control 1 bits.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;
   // interface status flags (active low)
   localparam int unsigned FLG_END  = 6;
   localparam int unsigned FLG_DEC  = 5;
   localparam int unsigned FLG_BUSY = 3;
   localparam int unsigned FLG_EN   = 1;
   // interface control enables
   localparam int unsigned IE_END = 6;
   localparam int unsigned IE_DEC = 5;
   localparam int unsigned IE_OUT = 1;
   // control 0 / control 1 bits
   localparam int unsigned C0_DEC  = 7;
   localparam int unsigned C0_AUTO = 4;
   localparam int unsigned C1_MODE = 3;
   localparam int unsigned C1_FORM = 2;
   localparam int unsigned C1_BANK = 0;
   // write map
   localparam logic [3:0] W_IFCTRL = 4'h1;
   localparam logic [3:0] W_CNT_LO = 4'h2;
   localparam logic [3:0] W_CNT_HI = 4'h3;
   localparam logic [3:0] W_DAC_LO = 4'h4;
   localparam logic [3:0] W_DAC_HI = 4'h5;
   localparam logic [3:0] W_TRIG   = 4'h6;
   localparam logic [3:0] W_ACK    = 4'h7;
   localparam logic [3:0] W_WA_LO  = 4'h8;
   localparam logic [3:0] W_WA_HI  = 4'h9;
   localparam logic [3:0] W_CTRL0  = 4'hA;
   localparam logic [3:0] W_CTRL1  = 4'hB;
   localparam logic [3:0] W_PT_LO  = 4'hC;
   localparam logic [3:0] W_PT_HI  = 4'hD;
   localparam logic [3:0] W_SRST   = 4'hF;
   // read map
   localparam logic [3:0] R_IFSTAT = 4'h1;
   localparam logic [3:0] R_CNT_LO = 4'h2;
   localparam logic [3:0] R_CNT_HI = 4'h3;
   localparam logic [3:0] R_HDR0   = 4'h4;
   localparam logic [3:0] R_HDR1   = 4'h5;
   localparam logic [3:0] R_HDR2   = 4'h6;
   localparam logic [3:0] R_HDR3   = 4'h7;
   localparam logic [3:0] R_PT_LO  = 4'h8;
   localparam logic [3:0] R_PT_HI  = 4'h9;
   localparam logic [3:0] R_WA_LO  = 4'hA;
   localparam logic [3:0] R_WA_HI  = 4'hB;
   localparam logic [3:0] R_STAT0  = 4'hC;
   localparam logic [3:0] R_STAT1  = 4'hD;
   localparam logic [3:0] R_STAT2  = 4'hE;
   localparam logic [3:0] R_STAT3  = 4'hF;
endpackage

// File: rtl/rp_index.sv
module rp_index #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             sel_we,
   input  logic [IDX_W-1:0] sel_idx,
   input  logic             soft_rst,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_n;

   always_comb begin
      idx_n = idx_q;
      if (soft_rst)
         idx_n = '0;
      else if (sel_we)
         idx_n = sel_idx;
      else if (acc && (idx_q != '0))
         idx_n = idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx_n;
   end

   assign idx = idx_q;

   p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !sel_we && !soft_rst && idx_q != '0) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
   p_idx_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !sel_we && !soft_rst && idx_q == '0) |=> idx_q == '0);
   p_idx_srst_r13: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> idx_q == '0);
endmodule

// File: rtl/rp_mode.sv
module rp_mode
   import ctl_regport_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] ctrl0,
   input  logic [DATA_W-1:0] ctrl1,
   output logic [DATA_W-1:0] stat2
);
   logic unused_mode;
   assign unused_mode = ^{ctrl0, ctrl1};

   always_comb begin
      stat2          = '0;
      stat2[C1_MODE] = ctrl1[C1_MODE];
      if (!ctrl0[C0_AUTO])
         stat2[C1_FORM] = ctrl1[C1_FORM];
   end
endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
   import ctl_regport_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned HDR_BYTES  = 4,
   parameter logic [31:0] HDR_RST    = 32'h0100_0000,
   parameter logic [7:0]  IFSTAT_RST = 8'hFF,
   parameter logic [7:0]  STAT3_IDLE = 8'h80,
   parameter logic [15:0] CNT_END    = 16'hF000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        idx_we,
   input  logic [IDX_W-1:0]            idx_in,
   input  logic                        rd_en,
   input  logic                        wr_en,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [DATA_W-1:0]           rd_data,
   input  logic                        xfer_end,
   input  logic                        dec_hit,
   input  logic [HDR_BYTES*DATA_W-1:0] dec_hdr,
   output logic [2*DATA_W-1:0]         cnt_val,
   output logic [2*DATA_W-1:0]         dac_val,
   output logic                        xfer_start,
   output logic                        xfer_abort,
   output logic                        irq
);
   localparam int unsigned CNT_W = 2 * DATA_W;
   localparam int unsigned HDR_W = HDR_BYTES * DATA_W;
   localparam int unsigned NIB   = DATA_W / 2;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("ctl_regport: DATA_W must be 8");
      end
      if (IDX_W != 4) begin : g_bad_iw
         $error("ctl_regport: IDX_W must be 4");
      end
      if (HDR_BYTES != 4) begin : g_bad_hb
         $error("ctl_regport: HDR_BYTES must be 4");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              soft_rst;
   logic              wr_act, rd_act;

   logic [DATA_W-1:0] ifstat_q, ifstat_n;
   logic [DATA_W-1:0] ifctrl_q, ifctrl_n;
   logic [DATA_W-1:0] ctrl0_q, ctrl0_n;
   logic [DATA_W-1:0] ctrl1_q, ctrl1_n;
   logic [DATA_W-1:0] stat0_q, stat0_n;
   logic [DATA_W-1:0] stat3_q, stat3_n;
   logic [DATA_W-1:0] stat2;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [CNT_W-1:0]  dac_q, dac_n;
   logic [CNT_W-1:0]  wa_q, wa_n;
   logic [CNT_W-1:0]  pt_q, pt_n;
   logic [HDR_W-1:0]  hdr_q, hdr_n;
   logic              irq_q, irq_n;
   logic              start_q, start_n;
   logic              abort_q, abort_n;
   logic [DATA_W-1:0] hbyte [HDR_BYTES];

   logic unused_bits;
   assign unused_bits = ^{ifctrl_q, ctrl0_q, ctrl1_q};

   assign wr_act   = wr_en;
   assign rd_act   = rd_en && !wr_en;
   assign soft_rst = wr_act && (idx == W_SRST);

   rp_index #(.IDX_W(IDX_W)) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (wr_en | rd_en),
      .sel_we   (idx_we),
      .sel_idx  (idx_in),
      .soft_rst (soft_rst),
      .idx      (idx)
   );

   rp_mode #(.DATA_W(DATA_W)) u_mode (
      .ctrl0 (ctrl0_q),
      .ctrl1 (ctrl1_q),
      .stat2 (stat2)
   );

   // header bytes as seen by the read port, bank chosen by control 1
   genvar gk;
   generate
      for (gk = 0; gk < HDR_BYTES; gk++) begin : g_hdr
         assign hbyte[gk] = ctrl1_q[C1_BANK] ? '0 : hdr_q[gk*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      case (idx)
         R_IFSTAT: rd_data = ifstat_q;
         R_CNT_LO: rd_data = cnt_q[DATA_W-1:0];
         R_CNT_HI: rd_data = cnt_q[CNT_W-1:DATA_W];
         R_HDR0, R_HDR1, R_HDR2, R_HDR3: rd_data = hbyte[idx[1:0]];
         R_PT_LO:  rd_data = pt_q[DATA_W-1:0];
         R_PT_HI:  rd_data = pt_q[CNT_W-1:DATA_W];
         R_WA_LO:  rd_data = wa_q[DATA_W-1:0];
         R_WA_HI:  rd_data = wa_q[CNT_W-1:DATA_W];
         R_STAT0:  rd_data = stat0_q;
         R_STAT1:  rd_data = '0;
         R_STAT2:  rd_data = stat2;
         R_STAT3:  rd_data = stat3_q;
         default:  rd_data = '1;
      endcase
   end

   // next state: engine/decoder pulses first, host access on top
   always_comb begin
      ifstat_n = ifstat_q;  ifctrl_n = ifctrl_q;
      ctrl0_n  = ctrl0_q;   ctrl1_n  = ctrl1_q;
      stat0_n  = stat0_q;   stat3_n  = stat3_q;
      cnt_n    = cnt_q;     dac_n    = dac_q;
      wa_n     = wa_q;      pt_n     = pt_q;
      hdr_n    = hdr_q;     irq_n    = irq_q;
      start_n  = 1'b0;      abort_n  = 1'b0;

      if (xfer_end) begin
         cnt_n              = CNT_END;
         ifstat_n[FLG_BUSY] = 1'b1;
         ifstat_n[FLG_EN]   = 1'b1;
         ifstat_n[FLG_END]  = 1'b0;
         if (ifctrl_q[IE_END]) irq_n = 1'b1;
      end

      if (dec_hit && ctrl0_q[C0_DEC]) begin
         hdr_n             = dec_hdr;
         stat3_n           = '0;
         ifstat_n[FLG_DEC] = 1'b0;
         if (ifctrl_q[IE_DEC]) irq_n = 1'b1;
      end

      if (wr_act) begin
         case (idx)
            W_IFCTRL: begin
               irq_n = (wr_data[IE_END] & ~ifstat_n[FLG_END]) |
                       (wr_data[IE_DEC] & ~ifstat_n[FLG_DEC]);
               if (!wr_data[IE_OUT]) begin
                  ifstat_n[FLG_BUSY] = 1'b1;
                  ifstat_n[FLG_EN]   = 1'b1;
                  abort_n            = 1'b1;
               end
               ifctrl_n = wr_data;
            end
            W_CNT_LO: cnt_n[DATA_W-1:0]     = wr_data;
            W_CNT_HI: cnt_n[CNT_W-1:DATA_W] = wr_data;
            W_DAC_LO: dac_n[DATA_W-1:0]     = wr_data;
            W_DAC_HI: dac_n[CNT_W-1:DATA_W] = wr_data;
            W_TRIG: begin
               if (ifctrl_q[IE_OUT]) begin
                  ifstat_n[FLG_BUSY]      = 1'b0;
                  ifstat_n[FLG_EN]        = 1'b0;
                  cnt_n[CNT_W-1 -: NIB]   = '0;
                  start_n                 = 1'b1;
               end
            end
            W_ACK: begin
               ifstat_n[FLG_END]     = 1'b1;
               cnt_n[CNT_W-1 -: NIB] = '0;
            end
            W_WA_LO: wa_n[DATA_W-1:0]     = wr_data;
            W_WA_HI: wa_n[CNT_W-1:DATA_W] = wr_data;
            W_CTRL0: begin
               stat0_n         = '0;
               stat0_n[C0_DEC] = wr_data[C0_DEC];
               ctrl0_n         = wr_data;
            end
            W_CTRL1: ctrl1_n = wr_data;
            W_PT_LO: pt_n[DATA_W-1:0]     = wr_data;
            W_PT_HI: pt_n[CNT_W-1:DATA_W] = wr_data;
            default: ;
         endcase
      end else if (rd_act && idx == R_STAT3) begin
         stat3_n           = STAT3_IDLE;
         ifstat_n[FLG_DEC] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         ifstat_q <= IFSTAT_RST;  ifctrl_q <= '0;
         ctrl0_q  <= '0;          ctrl1_q  <= '0;
         stat0_q  <= '0;          stat3_q  <= STAT3_IDLE;
         cnt_q    <= '0;          dac_q    <= '0;
         wa_q     <= '0;          pt_q     <= '0;
         hdr_q    <= HDR_RST;     irq_q    <= 1'b0;
         start_q  <= 1'b0;        abort_q  <= 1'b0;
      end else begin
         ifstat_q <= ifstat_n;    ifctrl_q <= ifctrl_n;
         ctrl0_q  <= ctrl0_n;     ctrl1_q  <= ctrl1_n;
         stat0_q  <= stat0_n;     stat3_q  <= stat3_n;
         cnt_q    <= cnt_n;       dac_q    <= dac_n;
         wa_q     <= wa_n;        pt_q     <= pt_n;
         hdr_q    <= hdr_n;       irq_q    <= irq_n;
         start_q  <= start_n;     abort_q  <= abort_n;
      end
   end

   assign cnt_val    = cnt_q;
   assign dac_val    = dac_q;
   assign xfer_start = start_q;
   assign xfer_abort = abort_q;
   assign irq        = irq_q;

   p_start_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (!ifstat_q[FLG_BUSY] && !ifstat_q[FLG_EN] && ifctrl_q[IE_OUT]));
   p_ack_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == W_ACK) |=> (cnt_q[CNT_W-1 -: NIB] == '0 && ifstat_q[FLG_END]));
   p_stat0_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == W_CTRL0) |=> stat0_q == ($past(wr_data) & 8'h80));
   p_stat2_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat2[C1_FORM] |-> !ctrl0_q[C0_AUTO]);
   p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en));
   p_abort_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort |-> (ifstat_q[FLG_BUSY] && ifstat_q[FLG_EN] && !ifctrl_q[IE_OUT]));
   p_end_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_end && !wr_en) |=> cnt_q == CNT_END);
   p_stat3_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && idx == R_STAT3) |=> (stat3_q == STAT3_IDLE && ifstat_q[FLG_DEC]));
endmodule

// File: tb/ctl_regport_tb.sv
module ctl_regport_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_we = 1'b0;
   logic [3:0]  idx_in = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        xfer_end = 1'b0;
   logic        dec_hit = 1'b0;
   logic [31:0] dec_hdr = '0;
   logic [15:0] cnt_val, dac_val;
   logic        xfer_start, xfer_abort, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ctl_regport u_dut (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_in(idx_in),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .xfer_end(xfer_end), .dec_hit(dec_hit), .dec_hdr(dec_hdr),
      .cnt_val(cnt_val), .dac_val(dac_val), .xfer_start(xfer_start),
      .xfer_abort(xfer_abort), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic sel(input logic [3:0] i);
      @(negedge clk); idx_we = 1'b1; idx_in = i;
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] exp);
      @(negedge clk);
      chk(req, {24'h0, rd_data}, {24'h0, exp});
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic pulse_end();
      @(negedge clk); xfer_end = 1'b1;
      @(negedge clk); xfer_end = 1'b0;
   endtask

   task automatic pulse_dec(input logic [31:0] h);
      @(negedge clk); dec_hit = 1'b1; dec_hdr = h;
      @(negedge clk); dec_hit = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rst_exp [15];
      rst_exp = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00,
                  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset values walked through the read map (R2), wrap to 0 (R1)
      chk("R4 irq", {31'h0, irq}, 32'h0);
      chk("R4 cnt", {16'h0, cnt_val}, 32'h0);
      chk("R4 start", {31'h0, xfer_start}, 32'h0);
      sel(4'h1);
      for (int i = 0; i < 15; i++) rd_chk("R4 reset map", rst_exp[i]);
      rd_chk("R1 wrap to index 0", 8'hFF);
      rd_chk("R1 index 0 holds", 8'hFF);

      // R7 / R8 sweep over control 0 and control 1
      for (int a = 0; a < 4; a++) begin
         for (int c = 0; c < 16; c++) begin
            logic [7:0] c0, c1, s2;
            c0 = {a[1], 2'b00, a[0], 4'h0};
            c1 = c[7:0];
            s2 = (c1 & 8'h08) | ((c0 & 8'h10) != 0 ? 8'h00 : (c1 & 8'h04));
            sel(4'hA); wr(c0); wr(c1);
            sel(4'hC);
            rd_chk("R7 status 0", c0 & 8'h80);
            rd_chk("R2 index 13 zero", 8'h00);
            rd_chk("R8 status 2", s2);
         end
      end
      sel(4'hA); wr(8'h00); wr(8'h00);

      // R4 write map for the 16-bit registers
      sel(4'h2); wr(8'h34); wr(8'h12); wr(8'hAB); wr(8'hCD);
      chk("R4 counter load", {16'h0, cnt_val}, 32'h1234);
      chk("R4 data address load", {16'h0, dac_val}, 32'hCDAB);
      sel(4'h8); wr(8'h56); wr(8'h78);
      sel(4'hC); wr(8'h9A); wr(8'hBC);
      sel(4'h2); rd_chk("R2 counter lo", 8'h34); rd_chk("R2 counter hi", 8'h12);
      sel(4'h8);
      rd_chk("R2 pointer lo", 8'h9A); rd_chk("R2 pointer hi", 8'hBC);
      rd_chk("R2 waddr lo", 8'h56);   rd_chk("R2 waddr hi", 8'h78);
      sel(4'hE); wr(8'h77);
      rd_chk("R1 step after index 14 write", 8'h80);
      sel(4'hE); rd_chk("R2 index 14 write ignored", 8'h00);

      // R10 abort, R5 trigger disabled then enabled
      sel(4'h1); wr(8'h00);
      chk("R10 abort pulse", {31'h0, xfer_abort}, 32'h1);
      sel(4'h3); wr(8'hF2);
      sel(4'h6); wr(8'h00);
      chk("R5 no start when disabled", {31'h0, xfer_start}, 32'h0);
      sel(4'h1); rd_chk("R5 status unchanged", 8'hFF);
      rd_chk("R5 cnt lo", 8'h34); rd_chk("R5 cnt hi kept", 8'hF2);
      sel(4'h1); wr(8'h42);
      chk("R10 no abort with enable", {31'h0, xfer_abort}, 32'h0);
      chk("R9 no pending", {31'h0, irq}, 32'h0);
      sel(4'h6); wr(8'h00);
      chk("R5 start pulse", {31'h0, xfer_start}, 32'h1);
      @(negedge clk);
      chk("R5 start one cycle", {31'h0, xfer_start}, 32'h0);
      sel(4'h1); rd_chk("R5 busy flags", 8'hF5);
      rd_chk("R5 cnt lo", 8'h34); rd_chk("R5 cnt hi nibble", 8'h02);

      // R11 transfer end, R6 acknowledge
      pulse_end();
      chk("R11 irq", {31'h0, irq}, 32'h1);
      chk("R11 counter", {16'h0, cnt_val}, 32'hF000);
      sel(4'h1); rd_chk("R11 status", 8'hBF);
      sel(4'h7); wr(8'h00);
      sel(4'h1); rd_chk("R6 end flag", 8'hFF);
      rd_chk("R6 cnt lo", 8'h00); rd_chk("R6 cnt hi", 8'h00);
      chk("R6 irq kept", {31'h0, irq}, 32'h1);

      // R9 interrupt re-evaluation
      sel(4'h1); wr(8'h02);
      chk("R9 irq cleared", {31'h0, irq}, 32'h0);
      pulse_end();
      chk("R11 irq masked", {31'h0, irq}, 32'h0);
      sel(4'h1); wr(8'h42);
      chk("R9 irq from pending end", {31'h0, irq}, 32'h1);
      sel(4'h1); wr(8'h22);
      chk("R9 irq dropped", {31'h0, irq}, 32'h0);
      sel(4'h6); wr(8'h00);
      sel(4'h1); rd_chk("R5 trigger with end pending", 8'hB5);
      sel(4'h1); wr(8'h40);
      chk("R10 abort", {31'h0, xfer_abort}, 32'h1);
      chk("R9 irq", {31'h0, irq}, 32'h1);
      sel(4'h1); rd_chk("R10 flags set", 8'hBF);
      sel(4'h7); wr(8'h00);

      // R3 header capture
      pulse_dec(32'hA1B2C3D4);
      sel(4'h4);
      rd_chk("R3 gated hdr0", 8'h00); rd_chk("R3 gated hdr1", 8'h00);
      rd_chk("R3 gated hdr2", 8'h00); rd_chk("R3 gated hdr3", 8'h01);
      sel(4'h1); rd_chk("R3 gated status", 8'hFF);
      sel(4'h1); wr(8'h22);
      sel(4'hA); wr(8'h80); wr(8'h00);
      pulse_dec(32'hA1B2C3D4);
      chk("R3 irq", {31'h0, irq}, 32'h1);
      sel(4'h4);
      rd_chk("R3 hdr0", 8'hD4); rd_chk("R3 hdr1", 8'hC3);
      rd_chk("R3 hdr2", 8'hB2); rd_chk("R3 hdr3", 8'hA1);
      sel(4'h1); rd_chk("R3 dec flag", 8'hDF);
      sel(4'hB); wr(8'h01);
      sel(4'h4);
      rd_chk("R3 bank1 hdr0", 8'h00); rd_chk("R3 bank1 hdr3", 8'h00);
      sel(4'hF); rd_chk("R3 status 3 valid", 8'h00);
      rd_chk("R12 wrapped to 0", 8'hFF);
      sel(4'hF); rd_chk("R12 status 3 idle", 8'h80);
      sel(4'h1); rd_chk("R12 dec flag cleared", 8'hFF);
      chk("R12 irq kept", {31'h0, irq}, 32'h1);
      sel(4'hB); wr(8'h00);

      // R14 acknowledge write and transfer end in the same cycle
      sel(4'h1); wr(8'h42);
      chk("R9 no pending", {31'h0, irq}, 32'h0);
      sel(4'h3); wr(8'h05);
      sel(4'h7);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; xfer_end = 1'b1;
      @(negedge clk); wr_en = 1'b0; xfer_end = 1'b0;
      chk("R14 counter", {16'h0, cnt_val}, 32'h0000);
      chk("R14 irq", {31'h0, irq}, 32'h1);
      sel(4'h1); rd_chk("R14 status", 8'hFF);

      // R13 soft reset wins over index load
      sel(4'h4); wr(8'h11); wr(8'h22);
      sel(4'hF);
      @(negedge clk); wr_en = 1'b1; idx_we = 1'b1; idx_in = 4'h5;
      @(negedge clk); wr_en = 1'b0; idx_we = 1'b0;
      chk("R13 irq", {31'h0, irq}, 32'h0);
      chk("R13 cnt", {16'h0, cnt_val}, 32'h0);
      chk("R13 dac", {16'h0, dac_val}, 32'h0);
      rd_chk("R13 index 0", 8'hFF);
      sel(4'h1); rd_chk("R13 status", 8'hFF);
      sel(4'h4);
      rd_chk("R13 hdr0", 8'h00); rd_chk("R13 hdr1", 8'h00);
      rd_chk("R13 hdr2", 8'h00); rd_chk("R13 hdr3", 8'h01);
      sel(4'hC); rd_chk("R13 status 0", 8'h00);

      // R1 index 0 write has no effect
      sel(4'h0); wr(8'h55);
      rd_chk("R1 index 0 write", 8'hFF);
      rd_chk("R1 index 0 still", 8'hFF);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule